// File: doc/BRIEF.md
# Ethernet VLAN Tag Inserter

This block sits in the transmit path and carries an Ethernet frame as a stream of bytes, one per beat, with start-of-frame and end-of-frame markers. With the first byte of every frame it also receives a sideband made of an insert-enable flag and a 16-bit tag control value. When the flag is set, the block places a four-byte 802.1Q tag directly after the two MAC addresses and moves every later byte back by four. When the flag is clear, the frame leaves unchanged.

Both sides use a valid/ready handshake. While the four tag bytes go out, the block holds its input ready low, so the next input byte waits at the source. No byte is lost, duplicated or reordered, whatever the stall pattern. The frame check sequence is not recomputed and short frames are not padded. A frame too short to reach the insertion point is forwarded as it is.

Top module: `vtag_inserter`

## Requirements
- R1: After reset, out_valid is low and in_ready follows out_ready while no frame is in progress.
- R2: A frame whose start beat has in_tag_en low leaves with the same bytes, the same length and start/end markers on the same bytes.
- R3: A frame whose start beat has in_tag_en high and which holds at least PRE_BYTES bytes (12 by default) leaves as: its first PRE_BYTES bytes unchanged, then 0x81, 0x00, then two tag control bytes, then its remaining bytes in order. It is therefore exactly four bytes longer.
- R4: The two tag control bytes are the in_tci value sampled on the start beat, bits 15:8 first and bits 7:0 second, so that priority (15:13), CFI (12) and VLAN ID (11:0) keep their positions. in_tci and in_tag_en on later beats of the frame have no effect.
- R5: A tagged frame of exactly PRE_BYTES bytes carries its end marker on the last tag control byte, not on its own last byte.
- R6: A tagged frame shorter than PRE_BYTES bytes leaves unchanged, with no tag.
- R7: While the tag bytes are being produced, in_ready stays low.
- R8: While out_valid is high and out_ready is low, out_valid, out_data, out_sop and out_eop stay stable into the next cycle.
- R9: Under any stall pattern on either side, every accepted byte comes out exactly once and in order.
- R10: Every output frame has out_sop on its first byte only and out_eop on its last byte only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block accepts the input byte this cycle |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | Input byte is the first of a frame |
| in_eop | input | 1 | Input byte is the last of a frame |
| in_tag_en | input | 1 | Insert a tag in this frame (read on the start beat) |
| in_tci | input | 16 | Tag control value (read on the start beat) |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Sink accepts the output byte this cycle |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | Output byte is the first of a frame |
| out_eop | output | 1 | Output byte is the last of a frame |

## Verification
The bench uses the default parameters: a 12-byte insertion point and the 0x8100 protocol identifier. It sweeps every frame length from 1 to 20 bytes, tagged and untagged. It repeats that sweep under three stall patterns: free flow, periodic sink stalls, and combined source gaps with bursty sink stalls. This covers the lengths below, at and above the insertion point, an end marker that falls on the insertion byte, and tag emission against a stalled sink. Sideband values on non-start beats are driven inverted so that any late sampling shows up in the output bytes.

// File: rtl/vtag_pkg.sv
package vtag_pkg;

  localparam int BYTE_W    = 8;
  localparam int TAG_BYTES = 4;
  localparam int TAG_IDX_W = $clog2(TAG_BYTES);

  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic              sop;
    logic              eop;
  } vt_beat_t;

  typedef enum logic {
    ST_PASS = 1'b0,
    ST_TAG  = 1'b1
  } vt_state_e;

  // Byte k of the inserted tag: protocol id high, low, control high, low.
  function automatic logic [BYTE_W-1:0] tag_byte(
    input logic [TAG_IDX_W-1:0] idx,
    input logic [15:0]          tpid,
    input logic [15:0]          tci
  );
    logic [BYTE_W-1:0] b;
    case (idx)
      2'd0:    b = tpid[15:8];
      2'd1:    b = tpid[7:0];
      2'd2:    b = tci[15:8];
      default: b = tci[7:0];
    endcase
    return b;
  endfunction

endpackage

// File: rtl/vtag_ctx.sv
// Per-frame context: sideband capture and byte position tracking.
module vtag_ctx #(
  parameter int PRE_BYTES = 12,
  parameter int TCI_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_fire,
  input  logic             in_sop,
  input  logic             in_tag_en,
  input  logic [TCI_W-1:0] in_tci,
  output logic             cur_en,
  output logic             at_insert,
  output logic [TCI_W-1:0] held_tci
);

  localparam int               POS_W    = $clog2(PRE_BYTES + 1);
  localparam logic [POS_W-1:0] LAST_PRE = POS_W'(PRE_BYTES - 1);
  localparam logic [POS_W-1:0] POS_SAT  = POS_W'(PRE_BYTES);

  logic             en_q,  en_d;
  logic [TCI_W-1:0] tci_q, tci_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic [POS_W-1:0] pos_now;

  // The start beat uses its own sideband; later beats use the held copy.
  always_comb begin
    pos_now   = in_sop ? '0 : pos_q;
    cur_en    = in_sop ? in_tag_en : en_q;
    at_insert = (pos_now == LAST_PRE);
    held_tci  = tci_q;
  end

  always_comb begin
    en_d  = en_q;
    tci_d = tci_q;
    pos_d = pos_q;
    if (in_sop) begin
      en_d  = in_tag_en;
      tci_d = in_tci;
    end
    if (pos_now == POS_SAT) begin
      pos_d = POS_SAT;
    end else begin
      pos_d = pos_now + POS_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      tci_q <= '0;
      pos_q <= '0;
    end else if (beat_fire) begin
      en_q  <= en_d;
      tci_q <= tci_d;
      pos_q <= pos_d;
    end
  end

endmodule

// File: rtl/vtag_seq.sv
// Tag emission sequencer: pass-through or tag-byte phase.
module vtag_seq
  import vtag_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 trigger,
  input  logic                 trigger_eop,
  input  logic                 advance,
  output logic                 tag_active,
  output logic [TAG_IDX_W-1:0] tag_idx,
  output logic                 tag_eop
);

  localparam logic [TAG_IDX_W-1:0] IDX_LAST = TAG_IDX_W'(TAG_BYTES - 1);

  vt_state_e            st_q,   st_d;
  logic [TAG_IDX_W-1:0] idx_q,  idx_d;
  logic                 eop_q,  eop_d;
  logic                 upd;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    eop_d = eop_q;
    upd   = 1'b0;
    case (st_q)
      ST_PASS: begin
        if (trigger) begin
          st_d  = ST_TAG;
          idx_d = '0;
          eop_d = trigger_eop;
          upd   = 1'b1;
        end
      end
      default: begin
        if (advance) begin
          upd = 1'b1;
          if (idx_q == IDX_LAST) begin
            st_d  = ST_PASS;
            idx_d = '0;
            eop_d = 1'b0;
          end else begin
            idx_d = idx_q + TAG_IDX_W'(1);
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_PASS;
      idx_q <= '0;
      eop_q <= 1'b0;
    end else if (upd) begin
      st_q  <= st_d;
      idx_q <= idx_d;
      eop_q <= eop_d;
    end
  end

  always_comb begin
    tag_active = (st_q == ST_TAG);
    tag_idx    = idx_q;
    tag_eop    = eop_q && (idx_q == IDX_LAST);
  end

endmodule

// File: rtl/vtag_out_stage.sv
// Output holding register with valid/ready flow control.
module vtag_out_stage
  import vtag_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     src_valid,
  input  vt_beat_t src_beat,
  input  logic     out_ready,
  output logic     can_load,
  output logic     out_valid,
  output vt_beat_t out_beat
);

  logic     v_q,    v_d;
  vt_beat_t beat_q, beat_d;
  logic     beat_en;

  always_comb begin
    can_load = !v_q || out_ready;
    v_d      = src_valid;
    beat_d   = src_beat;
    beat_en  = can_load && src_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
    end else if (can_load) begin
      v_q <= v_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
    end else if (beat_en) begin
      beat_q <= beat_d;
    end
  end

  always_comb begin
    out_valid = v_q;
    out_beat  = beat_q;
  end

endmodule

// File: rtl/vtag_inserter.sv
// Streaming 802.1Q tag inserter, one byte per beat.
module vtag_inserter
  import vtag_pkg::*;
#(
  parameter int          PRE_BYTES = 12,
  parameter logic [15:0] TPID      = 16'h8100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic              in_tag_en,
  input  logic [15:0]       in_tci,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop
);

  logic                 cur_en;
  logic                 at_insert;
  logic [15:0]          held_tci;
  logic                 tag_active;
  logic [TAG_IDX_W-1:0] tag_idx;
  logic                 tag_eop;
  logic                 can_load;
  logic                 beat_fire;
  logic                 trigger;
  logic                 advance;
  logic                 src_valid;
  vt_beat_t             src_beat;
  vt_beat_t             out_beat;

  always_comb begin
    in_ready  = can_load && !tag_active;
    beat_fire = in_valid && in_ready;
    trigger   = beat_fire && cur_en && at_insert;
    advance   = tag_active && can_load;
  end

  // Source select: tag bytes while the sequencer is active, else input.
  always_comb begin
    if (tag_active) begin
      src_valid     = 1'b1;
      src_beat.data = tag_byte(tag_idx, TPID, held_tci);
      src_beat.sop  = 1'b0;
      src_beat.eop  = tag_eop;
    end else begin
      src_valid     = in_valid;
      src_beat.data = in_data;
      src_beat.sop  = in_sop;
      src_beat.eop  = in_eop && !(cur_en && at_insert);
    end
  end

  vtag_ctx #(
    .PRE_BYTES (PRE_BYTES),
    .TCI_W     (16)
  ) u_ctx (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat_fire (beat_fire),
    .in_sop    (in_sop),
    .in_tag_en (in_tag_en),
    .in_tci    (in_tci),
    .cur_en    (cur_en),
    .at_insert (at_insert),
    .held_tci  (held_tci)
  );

  vtag_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .trigger     (trigger),
    .trigger_eop (in_eop),
    .advance     (advance),
    .tag_active  (tag_active),
    .tag_idx     (tag_idx),
    .tag_eop     (tag_eop)
  );

  vtag_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_valid (src_valid),
    .src_beat  (src_beat),
    .out_ready (out_ready),
    .can_load  (can_load),
    .out_valid (out_valid),
    .out_beat  (out_beat)
  );

  always_comb begin
    out_data = out_beat.data;
    out_sop  = out_beat.sop;
    out_eop  = out_beat.eop;
  end

endmodule

// File: rtl/vtag_inserter_chk.sv
module vtag_inserter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_sop,
  input logic       out_eop,
  input logic       tag_active
);

  logic open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
    end else if (out_valid && out_ready) begin
      open_q <= !out_eop;
    end
  end

  assert_sop_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sop |-> !open_q);

  assert_body_in_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_sop |-> open_q);

  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)
                                && $stable(out_sop) && $stable(out_eop));

  assert_tag_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tag_active |-> !in_ready);

  assert_tag_behind_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tag_active |-> out_valid && open_q == !out_sop);

endmodule

bind vtag_inserter vtag_inserter_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .out_sop    (out_sop),
  .out_eop    (out_eop),
  .tag_active (tag_active)
);

// File: tb/vtag_inserter_test.sv
`timescale 1ns/1ps
module vtag_inserter_test;

  localparam int PRE   = 12;
  localparam int MAXQ  = 8192;
  localparam int HALF  = 10;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  in_data;
  logic        in_sop;
  logic        in_eop;
  logic        in_tag_en;
  logic [15:0] in_tci;
  logic        out_valid;
  logic        out_ready;
  logic [7:0]  out_data;
  logic        out_sop;
  logic        out_eop;

  int checks;
  int fails;
  int wr_ptr;
  int rd_ptr;
  int mode;
  int cyc;
  bit monitor_on;
  bit done;

  logic [7:0] exp_data [MAXQ];
  logic       exp_sop  [MAXQ];
  logic       exp_eop  [MAXQ];
  int         exp_req  [MAXQ];
  bit         exp_stall[MAXQ];

  vtag_inserter uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_sop    (in_sop),
    .in_eop    (in_eop),
    .in_tag_en (in_tag_en),
    .in_tci    (in_tci),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_sop   (out_sop),
    .out_eop   (out_eop)
  );

  initial clk = 1'b0;
  always #HALF clk = ~clk;

  function automatic string req_name(input int code);
    case (code)
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [7:0] pay(input int fr, input int i);
    return 8'((fr * 7 + i * 13 + 1) & 255);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic s, input logic e,
                      input int req, input bit stall);
    exp_data[wr_ptr]  = d;
    exp_sop[wr_ptr]   = s;
    exp_eop[wr_ptr]   = e;
    exp_req[wr_ptr]   = req;
    exp_stall[wr_ptr] = stall;
    wr_ptr++;
  endtask

  // Expected output built from the requirements alone.
  task automatic build_expect(input int fr, input int len, input bit en,
                              input logic [15:0] tci);
    bit ins;
    int base;
    int olen;
    ins  = en && (len >= PRE);
    olen = ins ? len + 4 : len;
    base = en ? (len < PRE ? 6 : (len == PRE ? 5 : 3)) : 2;
    for (int i = 0; i < len; i++) begin
      push(pay(fr, i), i == 0, (!ins && i == len - 1) || (ins && i == len - 1 && len > PRE) , base, 1'b0);
      if (ins && i == PRE - 1) begin
        push(8'h81,      1'b0, 1'b0, 3, 1'b1);
        push(8'h00,      1'b0, 1'b0, 3, 1'b1);
        push(tci[15:8],  1'b0, 1'b0, 4, 1'b1);
        push(tci[7:0],   1'b0, len == PRE, (len == PRE) ? 5 : 4, 1'b0);
      end
    end
    if (olen < 0) $display("unreachable");
  endtask

  task automatic send_frame(input int fr, input int len, input bit en,
                            input logic [15:0] tci);
    for (int i = 0; i < len; i++) begin
      if (mode == 2 && (i % 4) == 3) begin
        @(negedge clk);
        in_valid = 1'b0;
      end
      @(negedge clk);
      in_valid  = 1'b1;
      in_data   = pay(fr, i);
      in_sop    = (i == 0);
      in_eop    = (i == len - 1);
      in_tag_en = (i == 0) ? en : !en;
      in_tci    = (i == 0) ? tci : ~tci;
      forever begin
        #5;
        if (in_ready) break;
        @(negedge clk);
      end
      @(posedge clk);
    end
    @(negedge clk);
    in_valid  = 1'b0;
    in_sop    = 1'b0;
    in_eop    = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Output monitor: drives out_ready, samples mid-cycle.
  logic [7:0] prev_data;
  logic       prev_sop;
  logic       prev_eop;
  bit         prev_hold;

  initial begin
    out_ready = 1'b1;
    prev_hold = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      case (mode)
        0:       out_ready = 1'b1;
        1:       out_ready = (cyc % 3) != 0;
        default: out_ready = (cyc % 5) < 2;
      endcase
      #5;
      if (monitor_on) begin
        if (prev_hold) begin
          check(out_valid && out_data == prev_data && out_sop == prev_sop
                && out_eop == prev_eop, "R8", "held beat changed",
                int'({out_valid, out_sop, out_eop, out_data}),
                int'({1'b1, prev_sop, prev_eop, prev_data}));
        end
        if (out_valid && out_ready) begin
          if (rd_ptr >= wr_ptr) begin
            check(1'b0, "R9", "extra output byte", int'(out_data), 0);
          end else begin
            check(out_data == exp_data[rd_ptr] && out_sop == exp_sop[rd_ptr]
                  && out_eop == exp_eop[rd_ptr], req_name(exp_req[rd_ptr]),
                  $sformatf("byte %0d {sop,eop,data}", rd_ptr),
                  int'({out_sop, out_eop, out_data}),
                  int'({exp_sop[rd_ptr], exp_eop[rd_ptr], exp_data[rd_ptr]}));
            if (exp_stall[rd_ptr]) begin
              check(!in_ready, "R7", "in_ready during tag", int'(in_ready), 0);
            end
            rd_ptr++;
          end
        end
        prev_hold = out_valid && !out_ready;
        prev_data = out_data;
        prev_sop  = out_sop;
        prev_eop  = out_eop;
      end
    end
  end

  // Watchdog.
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL R9 watchdog expired: actual %0d expected %0d bytes", rd_ptr, wr_ptr);
      finish_run();
    end
  end

  initial begin
    checks = 0; fails = 0; wr_ptr = 0; rd_ptr = 0; mode = 0; cyc = 0;
    monitor_on = 1'b0; done = 1'b0;
    rst_n = 1'b0;
    in_valid = 1'b0; in_data = '0; in_sop = 1'b0; in_eop = 1'b0;
    in_tag_en = 1'b0; in_tci = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #5;
    // R1: idle after reset
    check(!out_valid, "R1", "out_valid after reset", int'(out_valid), 0);
    check(in_ready == out_ready, "R1", "in_ready after reset", int'(in_ready), int'(out_ready));
    monitor_on = 1'b1;

    for (int m = 0; m < 3; m++) begin
      mode = m;
      for (int len = 1; len <= 20; len++) begin
        for (int t = 0; t < 2; t++) begin
          int fr;
          logic [15:0] tci;
          fr  = m * 40 + len * 2 + t;
          tci = {3'(fr % 8), 1'(fr % 2), 12'((fr * 37 + 5) % 4096)};
          build_expect(fr, len, t == 1, tci);
          send_frame(fr, len, t == 1, tci);
        end
      end
    end

    for (int k = 0; k < 2000 && rd_ptr < wr_ptr; k++) @(negedge clk);
    repeat (3) @(negedge clk);
    #5;
    check(rd_ptr == wr_ptr, "R9", "bytes delivered", rd_ptr, wr_ptr);
    check(!out_valid, "R9", "no stray output", int'(out_valid), 0);
    done = 1'b1;
    finish_run();
  end

endmodule